// File: doc/BRIEF.md
# Timed Signal-Routing Sequencer

The block works through a short, fixed program of timed steps. Each step picks one of four output lines, one of four input lines, and a hold time. For the whole time a step is active, the picked input is passed straight through to the picked output, and all other outputs stay at 0. When the hold time has run out, the next step takes over. Hold times are counted in half-second ticks, so a value such as 3.5 s is simply seven ticks. There is no need to work out a binary cycle count for each step.

The program is a parameter table of up to eight entries. A length parameter sets how many of those entries are used. A status vector shows which step is active, for example on a row of LEDs. When the last used step finishes, the block takes one of two paths. If the loop input is low in that final cycle, it parks in a quiet finished state. If the loop input is high in that final cycle, it starts again at step 0. Reset always restarts the program at step 0.

The state machine has two states. ST_RUN routes the current step. ST_DONE has every output and every status bit low. It has four transitions:

- ADVANCE (ST_RUN to ST_RUN, next step) happens when a step that is not the last one expires.
- WRAP (ST_RUN to ST_RUN, step 0) happens when the last step expires with loop high.
- FINISH (ST_RUN to ST_DONE) happens when the last step expires with loop low.
- HOLD (ST_DONE to ST_DONE) covers every cycle in ST_DONE until reset.

Top module: `route_sequencer`

## Requirements
- R1: While reset is asserted (active low, asynchronous), and in the first cycle after it is released, step 0 is active and the status vector equals 8'b0000_0001.
- R2: While a step is active, output line number `dst` equals input line number `src`. Line numbers are the bit indices of `out_lines` and `in_lines`, and the copy is combinational within the same cycle.
- R3: While a step is active, every output other than `dst` is 0.
- R4: A step with a hold of D ticks stays active for exactly D × TICK_CYCLES clock cycles from the cycle it is entered. The cycle counter and the tick counter both restart on entry.
- R5: The default program, as (dst, src, ticks), is step 0 = (0,0,4), step 1 = (1,2,7), step 2 = (2,1,6) and step 3 = (1,0,4). TICK_CYCLES defaults to 25,000,000, which is half a second at 50 MHz.
- R6: If `loop_en` is low in the final cycle of the last used step, the block enters ST_DONE. It then holds all outputs and the status vector at 0 until reset.
- R7: If `loop_en` is high in the final cycle of the last used step, step 0 becomes active on the next cycle.
- R8: In ST_RUN, the status vector is one-hot, with bit k set while step k is active.
- R9: Only steps 0 to NUM_STEPS−1 are ever active. Step NUM_STEPS is never entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Restart at step 0 after the last step instead of finishing |
| in_lines | input | 4 | Source lines, selected by bit index |
| out_lines | output | 4 | Destination lines, selected by bit index |
| step_status | output | 8 | One-hot active step, all zero when finished |

## Verification
Two functions can fall in the same cycle: the expiry of the last step, and the decision between WRAP and FINISH. The bench provokes this by flipping `loop_en` only in that final cycle, in both directions, with the flip taken from its own model's timing. The result is judged on the next cycle against the model, using the step index, the outputs and the status. A reset is also dropped into the middle of a step, to show that both counters restart together.

// File: rtl/seq_pkg.sv
package seq_pkg;

    parameter int IO_LINES  = 4;
    parameter int SEL_W     = $clog2(IO_LINES);
    parameter int DUR_W     = 8;
    parameter int MAX_STEPS = 8;
    parameter int STEP_W    = $clog2(MAX_STEPS);

    typedef struct packed {
        logic [SEL_W-1:0] dst;
        logic [SEL_W-1:0] src;
        logic [DUR_W-1:0] ticks;
    } step_t;

    typedef step_t [MAX_STEPS-1:0] program_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_DONE = 1'b1
    } seq_state_t;

    function automatic program_t default_program();
        program_t p;
        p = '0;
        p[0] = '{dst: SEL_W'(0), src: SEL_W'(0), ticks: DUR_W'(4)};
        p[1] = '{dst: SEL_W'(1), src: SEL_W'(2), ticks: DUR_W'(7)};
        p[2] = '{dst: SEL_W'(2), src: SEL_W'(1), ticks: DUR_W'(6)};
        p[3] = '{dst: SEL_W'(1), src: SEL_W'(0), ticks: DUR_W'(4)};
        return p;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int TICK_CYCLES = 25_000_000,
    parameter int DUR_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DUR_W-1:0] ticks,
    output logic             expire
);
    localparam int CYC_W = $clog2(TICK_CYCLES + 1);

    logic [CYC_W-1:0] cyc_q;
    logic [DUR_W-1:0] tick_q;
    logic             tick_end;
    logic             last_tick;

    assign tick_end  = (cyc_q == CYC_W'(TICK_CYCLES - 1));
    assign last_tick = ({1'b0, tick_q} + 1'b1) >= {1'b0, ticks};
    assign expire    = run && tick_end && last_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            tick_q <= '0;
        end else if (!run || expire) begin
            cyc_q  <= '0;
            tick_q <= '0;
        end else if (tick_end) begin
            cyc_q  <= '0;
            tick_q <= tick_q + 1'b1;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end

    // R4
    cyc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q < CYC_W'(TICK_CYCLES));

    // R4
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cyc_q == '0 && tick_q == '0));

endmodule

// File: rtl/seq_router.sv
module seq_router #(
    parameter int IO_LINES = 4,
    parameter int SEL_W    = 2
) (
    input  logic                active,
    input  logic [SEL_W-1:0]    dst,
    input  logic [SEL_W-1:0]    src,
    input  logic [IO_LINES-1:0] in_lines,
    output logic [IO_LINES-1:0] out_lines
);
    logic picked;
    assign picked = in_lines[src];

    for (genvar i = 0; i < IO_LINES; i++) begin : g_out
        assign out_lines[i] = active && (dst == SEL_W'(i)) && picked;
    end

    // R3
    always_comb begin
        single_out_chk: assert ($countones(out_lines) <= 1);
    end

endmodule

// File: rtl/route_sequencer.sv
module route_sequencer #(
    parameter int                TICK_CYCLES = 25_000_000,
    parameter int                NUM_STEPS   = 4,
    parameter seq_pkg::program_t PROGRAM     = seq_pkg::default_program()
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           loop_en,
    input  logic [seq_pkg::IO_LINES-1:0]   in_lines,
    output logic [seq_pkg::IO_LINES-1:0]   out_lines,
    output logic [seq_pkg::MAX_STEPS-1:0]  step_status
);
    import seq_pkg::*;

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    step_t             cur;
    logic              running;
    logic              expire;

    assign cur     = PROGRAM[step_q];
    assign running = (state_q == ST_RUN);

    seq_timer #(
        .TICK_CYCLES (TICK_CYCLES),
        .DUR_W       (DUR_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .ticks  (cur.ticks),
        .expire (expire)
    );

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_RUN: begin
                if (expire) begin
                    if (step_q != LAST_STEP) begin
                        step_d = step_q + 1'b1;
                    end else if (loop_en) begin
                        step_d = '0;
                    end else begin
                        state_d = ST_DONE;
                        step_d  = '0;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        step_status = '0;
        unique case (state_q)
            ST_RUN:  step_status[step_q] = 1'b1;
            ST_DONE: step_status = '0;
            default: step_status = '0;
        endcase
    end

    seq_router #(
        .IO_LINES (IO_LINES),
        .SEL_W    (SEL_W)
    ) i_router (
        .active    (running),
        .dst       (cur.dst),
        .src       (cur.src),
        .in_lines  (in_lines),
        .out_lines (out_lines)
    );

    // R8
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> $onehot0(step_status) && step_status != '0);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (out_lines == '0 && step_status == '0));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !running);

    // R4
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> $stable(step_q));

    // R9
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST_STEP);

endmodule

// File: tb/test_route_sequencer.sv
module test_route_sequencer;

    localparam int T = 3;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_en = 1'b0;
    logic [3:0] in_lines = 4'h0;
    logic [3:0] out_lines;
    logic [7:0] step_status;

    always #10 clk = ~clk;

    route_sequencer #(
        .TICK_CYCLES (T),
        .NUM_STEPS   (N)
    ) i_route_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_en     (loop_en),
        .in_lines    (in_lines),
        .out_lines   (out_lines),
        .step_status (step_status)
    );

    // R5 default program, written independently
    int m_dst [N] = '{0, 1, 2, 1};
    int m_src [N] = '{0, 2, 1, 0};
    int m_dur [N] = '{4, 7, 6, 4};

    int  m_step = 0;
    int  m_elapsed = 0;
    bit  m_done = 0;
    bit  m_moved = 0;
    bit  m_wrapped = 0;
    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    int  base_loop = 0;
    int  final_force = -1;
    bit  finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model: advances on every clock edge
    always @(posedge clk) begin
        m_moved   = 0;
        m_wrapped = 0;
        if (!rst_n) begin
            m_step = 0; m_elapsed = 0; m_done = 0;
        end else if (!m_done) begin
            m_elapsed++;
            if (m_elapsed == m_dur[m_step] * T) begin
                m_elapsed = 0;
                m_moved = 1;
                if (m_step == N - 1) begin
                    if (loop_en) begin m_step = 0; m_wrapped = 1; end
                    else m_done = 1;
                end else begin
                    m_step++;
                end
            end
        end
    end

    // compare and drive away from the active edge
    always @(negedge clk) begin
        int exp_out;
        int exp_stat;
        bit fin;
        if (!finished) begin
            cycles++;
            exp_out  = 0;
            exp_stat = 0;
            if (!m_done) begin
                exp_out  = in_lines[m_src[m_step]] << m_dst[m_step];
                exp_stat = 1 << m_step;
            end
            check(out_lines == 4'(exp_out), m_done ? "R6/R9" : "R2/R3/R5",
                  "out_lines", out_lines, exp_out);
            check(step_status == 8'(exp_stat),
                  m_done ? "R6" : (m_wrapped ? "R7" : (m_moved ? "R4" : "R8")),
                  "step_status", step_status, exp_stat);
            in_lines = 4'($urandom);
            fin = !m_done && (m_step == N - 1) && (m_elapsed == m_dur[m_step] * T - 1);
            if (fin && final_force >= 0) loop_en = final_force[0];
            else loop_en = base_loop[0];
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_cycles(3);
        // R1: held in reset
        check(step_status == 8'h01, "R1", "status in reset", step_status, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(step_status == 8'h01, "R1", "status after release", step_status, 1);

        // FINISH path with loop low
        base_loop = 0;
        wait_cycles(90);
        check(m_done == 1 && step_status == 0, "R6", "finished", step_status, 0);

        // reset in mid-step, then loop for two passes
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        base_loop = 1;
        wait_cycles(150);

        // loop high but dropped only in the final cycle -> FINISH
        final_force = 0;
        wait_cycles(80);
        check(m_done == 1, "R6", "finish on final-cycle drop", step_status, 0);

        // loop low but raised only in the final cycle -> WRAP
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        base_loop = 0;
        final_force = 1;
        wait_cycles(100);

        // reset mid-step while looping restarts counters
        wait_cycles(7);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wait_cycles(40);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule